// File: doc/BRIEF.md
# Preferential Ballot Entry Controller

This block runs vote entry on a single voting unit in a preferential election. Each candidate has a button. Pressing a button gives that candidate the next preference in turn: the first press becomes preference 1, the next press preference 2, and so on. A configuration input sets how many candidates take part, and buttons beyond that number are masked. A back input withdraws the most recent choice, so the voter can correct mistakes before submitting.

The unit powers up in the inactive state. It only accepts input after a booth-enable input has armed it. Submission is accepted only when every enabled candidate has a preference. After a submit, the unit locks until the outside transfer logic signals completion. The unit then wipes every preference and returns to inactive.

Each accepted press also writes the chosen candidate's index into a small press-order log, at the address given by the preference counter. The transfer logic reads this log through a read port. Display drivers and the network transfer sit outside this block.

Top module: `ballot_entry_ctrl`

## Requirements
- R1: Once synchronous reset is released, the unit is inactive: `idle_o`=1, `locked_o`=0, `ready_o`=0 and every display field is 0 (blank).
- R2: While inactive, candidate, back and submit inputs have no effect. A high `booth_enable_i` moves the unit to voting at the next edge, and `idle_o` is high exactly while the unit is inactive.
- R3: The count setting is one more than the number of candidates. Button bit k-1 belongs to candidate k (counting from 1). The enables form a chain: candidate k is enabled only if k < `cand_count_i` and candidate k-1 is enabled. A disabled candidate's press is ignored.
- R4: An accepted press stores the current counter value as that candidate's preference, and the counter then increments. The candidate's 4-bit display field `disp_o[4(k-1)+:4]` shows the stored value plus one. An unused candidate shows 0. Pressing an already used candidate is ignored.
- R5: An accepted press writes the candidate's 1-based binary index into the log at the address equal to the counter value before the press. `log_rd_data_o` returns the entry at `log_rd_addr_i` combinationally.
- R6: Only a rising edge of a button counts as a press, so holding a button does not repeat it. If more than one button rises in the same cycle, none of them is accepted.
- R7: A rising edge on back decrements the counter, which holds at 0 when already 0. It then clears the one candidate whose stored preference equals the new counter value, and that candidate becomes blank and selectable again.
- R8: `ready_o` is high only while voting with no enabled candidate left unused. A rising edge on submit is ignored unless `ready_o` is high. In the same cycle, a press takes precedence over back, and back takes precedence over submit.
- R9: An accepted submit raises `locked_o` at the next edge. While locked, buttons and back have no effect and the displays hold their values.
- R10: While locked, a high `xfer_done_i` clears all preferences, used flags and the counter, and returns the unit to inactive at the next edge. The next vote starts again at preference 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (wake-up) |
| booth_enable_i | input | 1 | Arms an inactive unit for one vote |
| cand_count_i | input | 5 | Number of candidates plus one |
| btn_i | input | 15 | Candidate buttons, bit k-1 for candidate k |
| back_i | input | 1 | Withdraw the most recent preference |
| submit_i | input | 1 | Submit the completed ballot |
| xfer_done_i | input | 1 | Transfer of the submitted ballot has finished |
| log_rd_addr_i | input | 4 | Press-order log read address |
| log_rd_data_o | output | 4 | Candidate index stored at the read address |
| disp_o | output | 60 | Per-candidate displayed preference, 0 means blank |
| ready_o | output | 1 | Ballot complete and may be submitted |
| idle_o | output | 1 | Unit inactive, waiting for booth enable |
| locked_o | output | 1 | Ballot submitted, awaiting transfer completion |

## Verification
The bound checker watches several rules on every cycle. Displays are blank whenever the unit is inactive. The unit is never locked unless it was ready one cycle earlier. Displays stay frozen for the whole locked period. A cycle with two or more rising buttons changes no display. The bench's scenarios are needed for the rest: the exact preference given to each candidate, which candidate a back withdraws, the count-driven masking chain, the log contents, and the restart from preference 1 after a transfer. These are compared against a reference model held in the bench.

// File: rtl/ballot_pkg.sv
package ballot_pkg;

    localparam int PREF_W    = 4;
    localparam int LOG_DEPTH = 1 << PREF_W;
    localparam int MAX_CAND  = LOG_DEPTH - 1;

    typedef enum logic [1:0] {
        UNIT_IDLE = 2'd0,
        UNIT_VOTE = 2'd1,
        UNIT_LOCK = 2'd2
    } unit_state_t;

    typedef logic [PREF_W-1:0] pref_t;

    typedef struct packed {
        logic  used;
        pref_t pref;
    } slot_t;

    // Display code: stored preference plus one, zero when the slot is unused.
    function automatic pref_t slot_display(input slot_t s);
        pref_t r;
        r = s.used ? pref_t'(s.pref + 1'b1) : '0;
        return r;
    endfunction

    // 1-based position of the lowest set bit, zero when none is set.
    function automatic pref_t lowest_index(input logic [MAX_CAND-1:0] v);
        pref_t r;
        r = '0;
        for (int k = MAX_CAND - 1; k >= 0; k--) begin
            if (v[k]) r = pref_t'(k + 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/bal_enable_chain.sv
module bal_enable_chain #(
    parameter int NUM_CAND = 15,
    parameter int CW       = 5
) (
    input  logic [CW-1:0]       cand_count_i,
    output logic [NUM_CAND-1:0] allowed_o
);
    // Each link passes its enable on; the first refused candidate blocks all above.
    always_comb begin
        allowed_o[0] = (CW'(1) < cand_count_i);
        for (int k = 1; k < NUM_CAND; k++) begin
            allowed_o[k] = allowed_o[k-1] & (CW'(k + 1) < cand_count_i);
        end
    end
endmodule

// File: rtl/bal_pref_counter.sv
module bal_pref_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_o <= '0;
        end else if (inc_i) begin
            cnt_o <= cnt_o + 1'b1;          // wraps to zero past the top
        end else if (dec_i && (cnt_o != '0)) begin
            cnt_o <= cnt_o - 1'b1;          // floors at zero
        end
    end
endmodule

// File: rtl/bal_cand_slot.sv
module bal_cand_slot
    import ballot_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_i,
    input  logic  set_i,
    input  logic  undo_i,
    input  pref_t undo_val_i,
    input  pref_t cur_i,
    output slot_t slot_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            slot_o <= '0;
        end else if (set_i) begin
            slot_o <= '{used: 1'b1, pref: cur_i};
        end else if (undo_i && slot_o.used && (slot_o.pref == undo_val_i)) begin
            slot_o <= '0;
        end
    end
endmodule

// File: rtl/bal_press_log.sv
module bal_press_log #(
    parameter int AW = 4,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/ballot_entry_ctrl.sv
module ballot_entry_ctrl
    import ballot_pkg::*;
#(
    parameter int NUM_CAND = MAX_CAND,
    localparam int CW      = $clog2(NUM_CAND + 2)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       booth_enable_i,
    input  logic [CW-1:0]              cand_count_i,
    input  logic [NUM_CAND-1:0]        btn_i,
    input  logic                       back_i,
    input  logic                       submit_i,
    input  logic                       xfer_done_i,
    input  logic [PREF_W-1:0]          log_rd_addr_i,
    output logic [PREF_W-1:0]          log_rd_data_o,
    output logic [NUM_CAND*PREF_W-1:0] disp_o,
    output logic                       ready_o,
    output logic                       idle_o,
    output logic                       locked_o
);
    // Previous input levels for edge detection.
    logic [NUM_CAND-1:0] btn_q;
    logic                back_q;
    logic                submit_q;

    always_ff @(posedge clk) begin
        btn_q    <= btn_i;
        back_q   <= back_i;
        submit_q <= submit_i;
    end

    logic [NUM_CAND-1:0] btn_rise;
    logic                back_rise;
    logic                submit_rise;

    assign btn_rise    = btn_i & ~btn_q;
    assign back_rise   = back_i & ~back_q;
    assign submit_rise = submit_i & ~submit_q;

    unit_state_t         state;
    logic [NUM_CAND-1:0] allowed;
    logic [NUM_CAND-1:0] used;
    logic [NUM_CAND-1:0] active;
    slot_t               slots [NUM_CAND];
    pref_t               cnt;
    pref_t               undo_val;
    pref_t               press_idx;
    logic [MAX_CAND-1:0] rise_wide;
    logic                voting;
    logic                all_filled;
    logic                press_ok;
    logic                back_ok;
    logic                undo_go;
    logic                submit_ok;
    logic                clear_all;

    bal_enable_chain #(
        .NUM_CAND (NUM_CAND),
        .CW       (CW)
    ) u_chain (
        .cand_count_i (cand_count_i),
        .allowed_o    (allowed)
    );

    assign active     = allowed & ~used;
    assign all_filled = ~|active;
    assign voting     = (state == UNIT_VOTE);

    always_comb begin
        rise_wide                = '0;
        rise_wide[NUM_CAND-1:0]  = btn_rise;
    end

    assign press_idx = lowest_index(rise_wide);
    assign press_ok  = voting && $onehot(btn_rise) && |(btn_rise & active);
    assign back_ok   = voting && !press_ok && back_rise;
    assign undo_go   = back_ok && (cnt != '0);
    assign undo_val  = cnt - 1'b1;
    assign submit_ok = voting && !press_ok && !back_rise && submit_rise && all_filled;
    assign clear_all = (state == UNIT_LOCK) && xfer_done_i;

    bal_pref_counter #(
        .W (PREF_W)
    ) u_counter (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clear_all),
        .inc_i (press_ok),
        .dec_i (back_ok),
        .cnt_o (cnt)
    );

    genvar k;
    generate
        for (k = 0; k < NUM_CAND; k++) begin : g_slot
            bal_cand_slot u_slot (
                .clk        (clk),
                .rst        (rst),
                .clr_i      (clear_all),
                .set_i      (press_ok && btn_rise[k]),
                .undo_i     (undo_go),
                .undo_val_i (undo_val),
                .cur_i      (cnt),
                .slot_o     (slots[k])
            );
            assign used[k]                    = slots[k].used;
            assign disp_o[k*PREF_W +: PREF_W] = slot_display(slots[k]);
        end
    endgenerate

    bal_press_log #(
        .AW (PREF_W),
        .DW (PREF_W)
    ) u_log (
        .clk     (clk),
        .rst     (rst),
        .we_i    (press_ok),
        .waddr_i (cnt),
        .wdata_i (press_idx),
        .raddr_i (log_rd_addr_i),
        .rdata_o (log_rd_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= UNIT_IDLE;
        end else begin
            unique case (state)
                UNIT_IDLE: if (booth_enable_i) state <= UNIT_VOTE;
                UNIT_VOTE: if (submit_ok)      state <= UNIT_LOCK;
                UNIT_LOCK: if (xfer_done_i)    state <= UNIT_IDLE;
                default:                       state <= UNIT_IDLE;
            endcase
        end
    end

    assign ready_o  = voting && all_filled;
    assign idle_o   = (state == UNIT_IDLE);
    assign locked_o = (state == UNIT_LOCK);
endmodule

// File: rtl/ballot_entry_chk.sv
module ballot_entry_chk #(
    parameter int NUM_CAND = 15,
    parameter int DW       = 60
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_CAND-1:0] btn_i,
    input logic                back_i,
    input logic [DW-1:0]       disp_o,
    input logic                ready_o,
    input logic                idle_o,
    input logic                locked_o
);
    AST_RESET_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (idle_o && !locked_o && disp_o == '0)); // R1

    AST_IDLE_BLANK: assert property (@(posedge clk) disable iff (rst)
        idle_o |-> (disp_o == '0)); // R10

    AST_SUBMIT_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> $past(ready_o)); // R8

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (locked_o && $past(locked_o)) |-> $stable(disp_o)); // R9

    AST_MULTI_PRESS_DROP: assert property (@(posedge clk) disable iff (rst)
        (!idle_o && !locked_o && !back_i && ($countones(btn_i & ~$past(btn_i)) > 1))
        |=> $stable(disp_o)); // R6
endmodule

bind ballot_entry_ctrl ballot_entry_chk #(
    .NUM_CAND (NUM_CAND),
    .DW       (NUM_CAND * ballot_pkg::PREF_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .btn_i    (btn_i),
    .back_i   (back_i),
    .disp_o   (disp_o),
    .ready_o  (ready_o),
    .idle_o   (idle_o),
    .locked_o (locked_o)
);

// File: tb/ballot_entry_ctrl_tb.sv
`timescale 1ns/1ps
module ballot_entry_ctrl_tb;
    localparam int NC = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          booth_enable_i = 1'b0;
    logic [4:0]    cand_count_i = 5'd0;
    logic [NC-1:0] btn_i = '0;
    logic          back_i = 1'b0;
    logic          submit_i = 1'b0;
    logic          xfer_done_i = 1'b0;
    logic [3:0]    log_rd_addr_i = '0;
    logic [3:0]    log_rd_data_o;
    logic [NC*4-1:0] disp_o;
    logic          ready_o;
    logic          idle_o;
    logic          locked_o;

    always #2.5 clk = ~clk;

    ballot_entry_ctrl #(.NUM_CAND(NC)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .booth_enable_i (booth_enable_i),
        .cand_count_i   (cand_count_i),
        .btn_i          (btn_i),
        .back_i         (back_i),
        .submit_i       (submit_i),
        .xfer_done_i    (xfer_done_i),
        .log_rd_addr_i  (log_rd_addr_i),
        .log_rd_data_o  (log_rd_data_o),
        .disp_o         (disp_o),
        .ready_o        (ready_o),
        .idle_o         (idle_o),
        .locked_o       (locked_o)
    );

    // Reference model, built from the requirements.
    int         n_chk = 0;
    int         n_fail = 0;
    bit         m_used [NC];
    int         m_pref [NC];
    int         m_log  [16];
    int         m_cnt = 0;
    int         m_st = 0;        // 0 inactive, 1 voting, 2 locked
    int         last_addr = 0;
    bit         have_log = 0;
    logic [NC-1:0] pb = '0;
    logic       pbk = 0, psb = 0;
    logic [4:0] cc = 5'd4;

    function automatic logic [NC*4-1:0] exp_disp();
        logic [NC*4-1:0] v = '0;
        for (int k = 0; k < NC; k++)
            if (m_used[k]) v[k*4 +: 4] = 4'(m_pref[k] + 1);
        return v;
    endfunction

    function automatic logic [NC-1:0] exp_active(input logic [4:0] c);
        logic [NC-1:0] a = '0;
        bit ok = 1;
        for (int k = 0; k < NC; k++) begin
            ok = ok && ((k + 1) < int'(c));
            a[k] = ok && !m_used[k];
        end
        return a;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic exp_ready;
        exp_ready = (m_st == 1) && (exp_active(cc) == '0);
        chk(disp_o == exp_disp(), "R4 display", 64'(disp_o), 64'(exp_disp()));
        chk(ready_o == exp_ready, "R8 ready", 64'(ready_o), 64'(exp_ready));
        chk(idle_o == (m_st == 0), "R2 idle", 64'(idle_o), 64'(m_st == 0));
        chk(locked_o == (m_st == 2), "R9 locked", 64'(locked_o), 64'(m_st == 2));
        if (have_log) begin
            log_rd_addr_i = 4'(last_addr);
            #0.5;
            chk(log_rd_data_o == 4'(m_log[last_addr]), "R5 log", 64'(log_rd_data_o), 64'(m_log[last_addr]));
        end
    endtask

    // Check the current outputs, then drive one cycle of stimulus and advance the model.
    task automatic step(input logic [NC-1:0] b, input logic bk, input logic sb,
                        input logic en, input logic xd);
        logic [NC-1:0] edges, act;
        @(negedge clk);
        compare_all();
        btn_i = b; back_i = bk; submit_i = sb; booth_enable_i = en; xfer_done_i = xd;
        cand_count_i = cc;
        edges = b & ~pb;
        if (m_st == 0) begin
            if (en) m_st = 1;
        end else if (m_st == 1) begin
            act = exp_active(cc);
            if ($countones(edges) == 1 && (edges & act) != '0) begin
                for (int k = 0; k < NC; k++) if (edges[k]) begin
                    m_used[k] = 1; m_pref[k] = m_cnt;
                    m_log[m_cnt] = k + 1; last_addr = m_cnt; have_log = 1;
                end
                m_cnt = (m_cnt + 1) % 16;
            end else if (bk && !pbk) begin
                if (m_cnt != 0) begin
                    m_cnt--;
                    for (int k = 0; k < NC; k++)
                        if (m_used[k] && m_pref[k] == m_cnt) m_used[k] = 0;
                end
            end else if (sb && !psb && act == '0) begin
                m_st = 2;
            end
        end else if (xd) begin
            for (int k = 0; k < NC; k++) begin m_used[k] = 0; m_pref[k] = 0; end
            m_cnt = 0; m_st = 0;
        end
        pb = b; pbk = bk; psb = sb;
    endtask

    task automatic peek_disp(input string tag);
        @(posedge clk); #1;
        chk(disp_o == exp_disp(), tag, 64'(disp_o), 64'(exp_disp()));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int k = 0; k < NC; k++) begin m_used[k] = 0; m_pref[k] = 0; end
        for (int a = 0; a < 16; a++) m_log[a] = 0;
        cand_count_i = cc;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
        // R1: inactive and blank after reset
        chk(idle_o && !locked_o && !ready_o && disp_o == '0, "R1 reset state",
            64'({idle_o, locked_o, ready_o}), 64'(3'b100));

        // R2: buttons ignored while inactive, then enable
        step(15'h0001, 0, 0, 0, 0);
        peek_disp("R2 press while inactive");
        step('0, 0, 0, 0, 0);
        step('0, 0, 0, 1, 0);
        // R3: candidate 4 is disabled with a setting of 4 (three candidates)
        step(15'h0008, 0, 0, 0, 0);
        peek_disp("R3 beyond-count press");
        step('0, 0, 0, 0, 0);
        // R4: candidate 2 takes preference 1, repeat press ignored
        step(15'h0002, 0, 0, 0, 0);
        peek_disp("R4 first press");
        step('0, 0, 0, 0, 0);
        step(15'h0002, 0, 0, 0, 0);
        step(15'h0002, 0, 0, 0, 0);   // R6: held button, no new edge
        step('0, 0, 0, 0, 0);
        // R7: back withdraws candidate 2, then back at zero holds
        step('0, 1, 0, 0, 0);
        peek_disp("R7 back clears last");
        step('0, 0, 0, 0, 0);
        step('0, 1, 0, 0, 0);
        step('0, 0, 0, 0, 0);
        // R6: two buttons rising together
        step(15'h0005, 0, 0, 0, 0);
        peek_disp("R6 two buttons together");
        step('0, 0, 0, 0, 0);
        step(15'h0001, 0, 0, 0, 0);
        step('0, 0, 0, 0, 0);
        step(15'h0002, 0, 0, 0, 0);
        step('0, 0, 0, 0, 0);
        // R8: submit while candidate 3 is still open is ignored
        step('0, 0, 1, 0, 0);
        step('0, 0, 0, 0, 0);
        step(15'h0004, 0, 0, 0, 0);
        step('0, 0, 0, 0, 0);
        // R9: submit, then presses and back while locked
        step('0, 0, 1, 0, 0);
        step('0, 0, 0, 0, 0);
        step(15'h0001, 1, 0, 0, 0);
        peek_disp("R9 locked input ignored");
        step('0, 0, 0, 0, 0);
        // R10: transfer done clears and returns to inactive; next vote restarts at 1
        step('0, 0, 0, 0, 1);
        peek_disp("R10 cleared after transfer");
        step('0, 0, 0, 1, 0);
        step(15'h0004, 0, 0, 0, 0);
        peek_disp("R10 restart at preference 1");
        step('0, 0, 0, 0, 0);

        // Constrained random phase with a fixed seed.
        void'($urandom(32'd24681));
        for (int i = 0; i < 4000; i++) begin
            logic [NC-1:0] b;
            int r;
            r = $urandom % 8;
            if (r < 3)      b = '0;
            else if (r < 7) b = NC'(1) << ($urandom % NC);
            else            b = (NC'(1) << ($urandom % NC)) | (NC'(1) << ($urandom % NC));
            if (m_st == 0 && ($urandom % 3) == 0) cc = 5'($urandom % 17);
            step(b, ($urandom % 10) == 0, ($urandom % 5) == 0,
                 ($urandom % 4) == 0, ($urandom % 4) == 0);
        end
        step('0, 0, 0, 0, 0);
        @(negedge clk);
        compare_all();
        finish_run();
    end
endmodule